// File: doc/BRIEF.md
# Reset Cause and Control Unit

This block drives the chip's internal hard and soft reset lines and keeps a record of what caused each reset. Four request sources feed it: an external hard reset pin, an external soft reset pin, a software watchdog expiry and a core checkstop indication. Each request is taken on its rising edge. A hard request first holds both reset outputs for a fixed number of cycles. It then releases the hard reset and holds only the soft reset for a second fixed number of cycles. A soft request runs the soft phase alone.

Software reads a sticky cause register, which it clears by writing ones. It also reads and writes a mode register whose single enable bit decides whether a checkstop starts a hard reset. Every hard sequence falls through into a soft phase, so one event can leave several cause bits set. The register interface is a plain 32-bit bus with address, write enable, write data and a combinational read data path.

Top module: `rst_cause_ctrl`

## Requirements
- R1: After power-on reset, `hard_rst` and `soft_rst` are low and both registers read 0.
- R2: A rising edge on `ext_hard_req`, on `wdog_expire`, or on `core_chkstop` while the enable is set raises `hard_rst` and `soft_rst` from the next cycle. They stay high together for HARD_CYC cycles. After that only `soft_rst` stays high, for SOFT_CYC cycles, and then both go low.
- R3: A rising edge on `ext_soft_req` while idle raises only `soft_rst`, for SOFT_CYC cycles. `hard_rst` stays low.
- R4: The cause register sits at address 0x00. Bit 0 is the hard-reset cause and is set when any hard sequence starts. Bit 1 is the soft-reset cause and is set by a soft request edge or by the hard-to-soft transition. Bit 2 is the checkstop cause and bit 3 the watchdog cause. After a watchdog reset the register reads 0xB.
- R5: Cause bits are sticky. Later resets and later events never clear them.
- R6: Writing 1 to a cause bit clears it and writing 0 leaves it unchanged. Bits 31:4 always read 0.
- R7: The mode register sits at address 0x04 and its only bit is bit 0, the checkstop reset enable. Writes to bits 31:1 are ignored and those bits read 0.
- R8: With the enable at 0, a checkstop edge raises neither reset output and sets no cause bit.
- R9: A hard sequence returns the mode register to 0.
- R10: A hard request that arrives during a soft-only sequence restarts the sequence from the hard phase, with the full HARD_CYC and SOFT_CYC lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_hard_req | input | 1 | External hard reset request |
| ext_soft_req | input | 1 | External soft reset request |
| wdog_expire | input | 1 | Software watchdog expiry |
| core_chkstop | input | 1 | Core has entered checkstop |
| reg_addr | input | ADDR_W | Register bus address |
| reg_we | input | 1 | Register bus write enable |
| reg_wdata | input | 32 | Register bus write data |
| reg_rdata | output | 32 | Register bus read data |
| hard_rst | output | 1 | Internal hard reset |
| soft_rst | output | 1 | Internal soft reset |

## Verification
The assertions assume that requests are levels the block samples on its own clock. A request counts only where a low sample is followed by a high one. They also assume that power-on reset is applied before any request or bus access. The bench meets these assumptions: it drives every input at the falling edge, holds each request high for exactly one cycle, and returns it low before the next request. It issues register writes only while no sequence is running. The only exception is the restart case, where it deliberately places a hard request in the middle of a soft phase.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HARD = 2'd1,
    SEQ_SOFT = 2'd2
  } seq_state_e;

  // big-endian bit number (0 = MSB) to vector index
  function automatic int be_idx(input int n);
    return 31 - n;
  endfunction

  localparam int ST_HARD = be_idx(31);
  localparam int ST_SOFT = be_idx(30);
  localparam int ST_CHK  = be_idx(29);
  localparam int ST_WDOG = be_idx(28);
  localparam int MD_CSEN = be_idx(31);

  localparam logic [31:0] ST_MASK = 32'h0000_000F;

  localparam int REQ_N    = 4;
  localparam int RQ_HARD  = 0;
  localparam int RQ_SOFT  = 1;
  localparam int RQ_WDOG  = 2;
  localparam int RQ_CHK   = 3;

  // sticky update: events win over a same-cycle clear
  function automatic logic [31:0] sticky_next(input logic [31:0] cur,
                                              input logic [31:0] set,
                                              input logic [31:0] clr);
    return ((cur & ~clr) | set) & ST_MASK;
  endfunction

endpackage

// File: rtl/rcc_edge.sv
module rcc_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) lvl_q[g] <= 1'b0;
      else        lvl_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~lvl_q[g];
  end
endmodule

// File: rtl/rcc_seq.sv
module rcc_seq
  import rcc_pkg::*;
#(
  parameter int HARD_CYC = 16,
  parameter int SOFT_CYC = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic hard_trig,
  input  logic soft_trig,
  output logic hard_o,
  output logic soft_o,
  output logic soft_entry
);
  localparam int MAXC  = (HARD_CYC > SOFT_CYC) ? HARD_CYC : SOFT_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] H_LAST = CNT_W'(HARD_CYC - 1);
  localparam logic [CNT_W-1:0] S_LAST = CNT_W'(SOFT_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    if (hard_trig) begin
      state_d = SEQ_HARD;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SEQ_HARD: if (cnt_q == H_LAST) begin
          state_d = SEQ_SOFT;
          cnt_d   = '0;
        end
        SEQ_SOFT: if (soft_trig) begin
          cnt_d = '0;
        end else if (cnt_q == S_LAST) begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end
        default: begin
          cnt_d = '0;
          if (soft_trig) state_d = SEQ_SOFT;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign hard_o     = (state_q == SEQ_HARD);
  assign soft_o     = (state_q != SEQ_IDLE);
  assign soft_entry = (state_q == SEQ_HARD) && (cnt_q == H_LAST) && !hard_trig;

  // R2
  hard_holds_soft_chk: assert property (@(posedge clk) disable iff (!por_n)
    hard_o |-> soft_o);

  // R2
  hard_start_chk: assert property (@(posedge clk) disable iff (!por_n)
    hard_trig |=> hard_o);

  // R3
  soft_only_chk: assert property (@(posedge clk) disable iff (!por_n)
    (soft_trig && !hard_trig && !hard_o) |=> (soft_o && !hard_o));
endmodule

// File: rtl/rcc_regs.sv
module rcc_regs
  import rcc_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] MODE_ADDR   = 'h04
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [31:0]       set_mask,
  input  logic              hard_active,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              chk_en
);
  logic [31:0] stat_q;
  logic [31:0] clr_w;
  logic        sel_stat, sel_mode;

  assign sel_stat = (addr == STATUS_ADDR);
  assign sel_mode = (addr == MODE_ADDR);
  assign clr_w    = (we && sel_stat) ? (wdata & ST_MASK) : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) stat_q <= '0;
    else        stat_q <= sticky_next(stat_q, set_mask, clr_w);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               chk_en <= 1'b0;
    else if (hard_active)     chk_en <= 1'b0;
    else if (we && sel_mode)  chk_en <= wdata[MD_CSEN];
  end

  always_comb begin
    rdata = '0;
    if (sel_stat)      rdata = stat_q;
    else if (sel_mode) rdata[MD_CSEN] = chk_en;
  end

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    ((($past(stat_q) & ~$past(clr_w)) & ~stat_q) == 32'h0));

  // R9
  mode_cleared_chk: assert property (@(posedge clk) disable iff (!por_n)
    hard_active |=> !chk_en);
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] MODE_ADDR   = 'h04,
  parameter int                HARD_CYC    = 16,
  parameter int                SOFT_CYC    = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_hard_req,
  input  logic              ext_soft_req,
  input  logic              wdog_expire,
  input  logic              core_chkstop,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              hard_rst,
  output logic              soft_rst
);
  logic [REQ_N-1:0] req_lvl, req_rise;
  logic             chk_en;
  logic             hard_trig, soft_trig, soft_entry, chk_hit;
  logic [31:0]      set_mask;

  assign req_lvl[RQ_HARD] = ext_hard_req;
  assign req_lvl[RQ_SOFT] = ext_soft_req;
  assign req_lvl[RQ_WDOG] = wdog_expire;
  assign req_lvl[RQ_CHK]  = core_chkstop;

  rcc_edge #(.N(REQ_N)) u_edge (
    .clk(clk), .por_n(por_n), .lvl(req_lvl), .rise(req_rise)
  );

  assign chk_hit   = req_rise[RQ_CHK] & chk_en;
  assign hard_trig = req_rise[RQ_HARD] | req_rise[RQ_WDOG] | chk_hit;
  assign soft_trig = req_rise[RQ_SOFT];

  rcc_seq #(.HARD_CYC(HARD_CYC), .SOFT_CYC(SOFT_CYC)) u_seq (
    .clk(clk), .por_n(por_n), .hard_trig(hard_trig), .soft_trig(soft_trig),
    .hard_o(hard_rst), .soft_o(soft_rst), .soft_entry(soft_entry)
  );

  always_comb begin
    set_mask          = '0;
    set_mask[ST_HARD] = hard_trig;
    set_mask[ST_SOFT] = soft_trig | soft_entry;
    set_mask[ST_CHK]  = chk_hit;
    set_mask[ST_WDOG] = req_rise[RQ_WDOG];
  end

  rcc_regs #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .MODE_ADDR(MODE_ADDR)) u_regs (
    .clk(clk), .por_n(por_n), .set_mask(set_mask), .hard_active(hard_rst),
    .addr(reg_addr), .we(reg_we), .wdata(reg_wdata), .rdata(reg_rdata),
    .chk_en(chk_en)
  );

  // R8
  chk_gated_chk: assert property (@(posedge clk) disable iff (!por_n)
    (req_rise[RQ_CHK] && !chk_en && !soft_rst && !req_rise[RQ_HARD]
     && !req_rise[RQ_SOFT] && !req_rise[RQ_WDOG]) |=> !soft_rst);
endmodule

// File: tb/rst_cause_ctrl_bench.sv
module rst_cause_ctrl_bench;
  localparam int HC = 16;
  localparam int SC = 16;
  localparam logic [7:0] A_ST = 8'h00;
  localparam logic [7:0] A_MD = 8'h04;
  localparam int I_HARD = 0, I_SOFT = 1, I_WDOG = 2, I_CHK = 3;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic [3:0]  req = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        hard_rst, soft_rst;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  h;
    logic  s;
    string tag;
  } item_t;
  item_t sb_q[$];
  item_t cur;

  always #10 clk = ~clk;

  rst_cause_ctrl #(.HARD_CYC(HC), .SOFT_CYC(SC)) u_rst_cause_ctrl (
    .clk(clk), .por_n(por_n),
    .ext_hard_req(req[I_HARD]), .ext_soft_req(req[I_SOFT]),
    .wdog_expire(req[I_WDOG]), .core_chkstop(req[I_CHK]),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .hard_rst(hard_rst), .soft_rst(soft_rst)
  );

  // monitor: compares output pair against scoreboard each cycle
  always @(negedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      checks++;
      if (hard_rst !== cur.h || soft_rst !== cur.s) begin
        errors++;
        $display("FAIL %s: hard/soft actual=%b%b expected=%b%b", cur.tag,
                 hard_rst, soft_rst, cur.h, cur.s);
      end
    end
  end

  task automatic push_seq(input int hn, input int sn, input int tl, input string tag);
    for (int i = 0; i < hn; i++) sb_q.push_back('{1'b1, 1'b1, tag});
    for (int i = 0; i < sn; i++) sb_q.push_back('{1'b0, 1'b1, tag});
    for (int i = 0; i < tl; i++) sb_q.push_back('{1'b0, 1'b0, tag});
  endtask

  task automatic fire(input int idx, input int hn, input int sn, input int tl,
                      input string tag);
    @(negedge clk);
    req[idx] = 1'b1;
    #2;
    push_seq(hn, sn, tl, tag);
    @(negedge clk);
    req[idx] = 1'b0;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_check(input logic [7:0] a, input logic [31:0] exp,
                           input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: reg[%0h] actual=%h expected=%h", tag, a, reg_rdata, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    // R1 reset state
    push_seq(0, 0, 3, "R1");
    drain();
    reg_check(A_ST, 32'h0, "R1");
    reg_check(A_MD, 32'h0, "R1");

    // R2 watchdog hard sequence, R4 cause encoding
    fire(I_WDOG, HC, SC, 3, "R2");
    drain();
    reg_check(A_ST, 32'hB, "R4");

    // R6 write-one-to-clear
    reg_write(A_ST, 32'h0);
    reg_check(A_ST, 32'hB, "R6");
    reg_write(A_ST, 32'h2);
    reg_check(A_ST, 32'h9, "R6");
    reg_write(A_ST, 32'hFFFF_FFFF);
    reg_check(A_ST, 32'h0, "R6");

    // R8 checkstop with enable low
    fire(I_CHK, 0, 0, 40, "R8");
    drain();
    reg_check(A_ST, 32'h0, "R8");

    // R7 reserved mode bits
    reg_write(A_MD, 32'hFFFF_FFFF);
    reg_check(A_MD, 32'h1, "R7");

    // R2 checkstop hard sequence when enabled; R4, R9
    fire(I_CHK, HC, SC, 3, "R2");
    drain();
    reg_check(A_ST, 32'h7, "R4");
    reg_check(A_MD, 32'h0, "R9");

    // R5 sticky across a later soft reset
    fire(I_SOFT, 0, SC, 3, "R5");
    drain();
    reg_check(A_ST, 32'h7, "R5");
    reg_write(A_ST, 32'hF);

    // R3 soft-only sequence
    fire(I_SOFT, 0, SC, 3, "R3");
    drain();
    reg_check(A_ST, 32'h2, "R3");
    reg_write(A_ST, 32'hF);

    // R10 hard request mid soft phase restarts from hard
    fire(I_SOFT, 0, 5, 0, "R10");
    repeat (3) @(negedge clk);
    fire(I_HARD, HC, SC, 3, "R10");
    drain();
    reg_check(A_ST, 32'h3, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule